// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counters. Each one is kept as a low byte and a high byte. Each timer has its own configuration nibble, which holds:

- a 2-bit mode field;
- a source select (machine-cycle tick or falling edges on an external count pin);
- a gate enable that makes counting wait on an external gate pin.

Each timer also has a run bit and a sticky overflow flag.

The same counting datapath is used in four modes:

- a 13-bit mode, where a 5-bit prescaler sits below an 8-bit count;
- a plain 16-bit mode;
- an 8-bit mode that reloads itself from the high byte;
- a split mode. Here timer 0 becomes two independent 8-bit counters, and its high byte takes over timer 1's run bit and overflow flag.

Software reaches the block through one byte-wide write port with a 3-bit register select. The two count values and both flags are driven out continuously. An acknowledge strobe per flag lets an interrupt controller clear a flag after taking its event.

Top module: `twin_timer`

## Requirements
- R1: While rst_n is low at a clock edge, both counts, both flags, both run bits and the configuration byte become zero.
- R2: A timer advances only when its run bit is 1 and either its gate enable is 0 or its gate pin is 1. With source select 0 it advances once per cycle in which tick is 1.
- R3: With source select 1, the count pin is sampled on every tick. The timer advances on a tick where the previous sample was 1 and the pin is now 0. The stored sample is 0 after reset, and pulses that fall between ticks are not seen.
- R4: Mode code 0 counts in low-byte bits [4:0] as a prescaler. When the prescaler wraps it steps the high byte. Low-byte bits [7:5] never change. The flag is set when both the high byte and the prescaler roll over from all ones.
- R5: Mode code 1 counts {high, low} as one 16-bit value. The flag is set on the step from 0xFFFF to 0x0000.
- R6: Mode code 2 steps the low byte only. On a step from 0xFF, the low byte loads the high byte and the flag is set. The high byte is left alone.
- R7: When timer 1 is in mode code 3, its count holds and never sets a flag.
- R8: When timer 0 is in mode code 3:
  - its low byte is an 8-bit counter that uses timer 0's run, gate and source, and sets flag 0;
  - its high byte steps on every tick while run bit 1 is set, and sets flag 1 on a wrap from 0xFF;
  - timer 1 keeps counting under its own controls, but its overflow no longer sets flag 1.
- R9: Flags stay set until cleared. The ways a flag changes, in order of priority:
  - a write to select 5 sets both flags to that write's value (highest);
  - an overflow sets the flag;
  - flag_ack clears it (lowest).
- R10: Register writes use these selects:
  - select 0 writes timer 0 low, and select 1 writes timer 0 high;
  - select 2 writes timer 1 low, and select 3 writes timer 1 high;
  - select 4 writes the configuration byte. Bits [1:0] are timer 0's mode, bit 2 its source select and bit 3 its gate enable. Bits [7:4] hold the same fields for timer 1;
  - select 5 writes run bits at [1:0] and flags at [3:2].

  A write to a count byte wins over a step in the same cycle. In modes 0 to 2 it cancels that timer's step for that cycle. In split mode it cancels only the step of the byte being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Machine-cycle enable |
| cnt_pin | input | 2 | External count pins, one per timer |
| gate_pin | input | 2 | External gate pins, one per timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | BYTE_W | Write data |
| flag_ack | input | 2 | Per-flag clear strobe |
| cnt0 | output | 2*BYTE_W | Timer 0 count {high, low} |
| cnt1 | output | 2*BYTE_W | Timer 1 count {high, low} |
| ovf_flag | output | 2 | Overflow flags, bit i for timer i |

## Verification
Each mode is started from a preload close to its wrap point. This separates the different carry rules: the 5-bit prescaler carry, the full 16-bit carry, the reload taken from the high byte, and the split carry into the borrowed flag.

The gate pin is toggled while the timer runs, to show that counting pauses and resumes. In counter mode, the count pin is toggled both slower and faster than the tick. This shows that only falls seen between two ticks are counted.

A random phase then mixes writes, acknowledges, pin activity and mode changes. This exercises the priority between a write, an overflow and an acknowledge that land in the same cycle. A behavioural reference model is compared against every output on every clock.

// File: rtl/twin_timer_pkg.sv
// Shared types for the dual timer/counter: mode codes, the per-timer
// configuration nibble layout and register select codes.
package twin_timer_pkg;

    typedef enum logic [1:0] {
        MODE_PRESCALED = 2'd0,
        MODE_WIDE      = 2'd1,
        MODE_RELOAD    = 2'd2,
        MODE_SPLIT     = 2'd3
    } tmode_e;

    // One timer's configuration nibble: gate[3], source[2], mode[1:0]
    typedef struct packed {
        logic   gate_en;
        logic   use_pin;
        tmode_e mode;
    } tcfg_t;

    localparam logic [2:0] SEL_T0_LO   = 3'd0;
    localparam logic [2:0] SEL_T0_HI   = 3'd1;
    localparam logic [2:0] SEL_T1_LO   = 3'd2;
    localparam logic [2:0] SEL_T1_HI   = 3'd3;
    localparam logic [2:0] SEL_CFG     = 3'd4;
    localparam logic [2:0] SEL_RUNFLAG = 3'd5;

endpackage

// File: rtl/tt_pin_sampler.sv
// Samples N external pins once per tick and reports a falling edge
// (previous sample high, current pin low) in the tick cycle.
// Assumes pins are already synchronised to clk.
module tt_pin_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] samp_q;

    // hold the last tick's sample of each pin
    always_ff @(posedge clk) begin
        if (!rst_n)    samp_q <= '0;
        else if (tick) samp_q <= pin;
    end

    assign fall = {N{tick}} & samp_q & ~pin;
endmodule

// File: rtl/tt_unit.sv
// One timer's low/high byte pair and its four-mode step logic.
// SPLIT_OK selects whether mode 3 splits the pair (timer 0) or holds it
// (timer 1). Writes to a byte override any step of that byte's unit.
module tt_unit
    import twin_timer_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmode_e            mode,
    input  logic              step,
    input  logic              hi_step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_hi
);
    localparam int WIDE_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] B_ONE = 1;
    localparam logic [PRE_W-1:0]  P_ONE = 1;
    localparam logic [WIDE_W-1:0] W_ONE = 1;

    logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic              split, whole_go;

    assign split    = SPLIT_OK ? (mode == MODE_SPLIT) : 1'b0;
    assign whole_go = step & ~wr_lo & ~wr_hi;

    // next-state for both bytes and the overflow pulses
    always_comb begin
        lo_d     = lo_q;
        hi_d     = hi_q;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        unique case (mode)
            MODE_PRESCALED: if (whole_go) begin
                if (&lo_q[PRE_W-1:0]) begin
                    lo_d[PRE_W-1:0] = '0;
                    hi_d            = hi_q + B_ONE;
                    ovf_main        = &hi_q;
                end else begin
                    lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + P_ONE;
                end
            end
            MODE_WIDE: if (whole_go) begin
                {hi_d, lo_d} = {hi_q, lo_q} + W_ONE;
                ovf_main     = &{hi_q, lo_q};
            end
            MODE_RELOAD: if (whole_go) begin
                if (&lo_q) begin
                    lo_d     = hi_q;
                    ovf_main = 1'b1;
                end else begin
                    lo_d = lo_q + B_ONE;
                end
            end
            MODE_SPLIT: if (split) begin
                if (step & ~wr_lo) begin
                    lo_d     = lo_q + B_ONE;
                    ovf_main = &lo_q;
                end
                if (hi_step & ~wr_hi) begin
                    hi_d   = hi_q + B_ONE;
                    ovf_hi = &hi_q;
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_d = wr_data;
        if (wr_hi) hi_d = wr_data;
    end

    // byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo = lo_q;
    assign hi = hi_q;
endmodule

// File: rtl/tt_flags.sv
// Sticky overflow flags: a write loads them, else a set wins over an
// acknowledge in the same cycle.
module tt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    input  logic         wr,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_q;

    // flag register with write > set > ack priority
    always_ff @(posedge clk) begin
        if (!rst_n)  flag_q <= '0;
        else if (wr) flag_q <= wr_val;
        else         flag_q <= set | (flag_q & ~ack);
    end

    assign flag = flag_q;
endmodule

// File: rtl/twin_timer.sv
// Two multi-mode timer/counters with gating, external edge counting and
// sticky overflow flags. Assumes BYTE_W >= 8 (the configuration and
// run/flag registers take the low byte of wr_data) and synchronous pins.
module twin_timer
    import twin_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          cnt_pin,
    input  logic [1:0]          gate_pin,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [1:0]          flag_ack,
    output logic [2*BYTE_W-1:0] cnt0,
    output logic [2*BYTE_W-1:0] cnt1,
    output logic [1:0]          ovf_flag
);
    localparam int NT = 2;

    logic [7:0]                  ctrl_q;
    logic [NT-1:0]               run_q;
    logic [NT-1:0]               fall, inc, ovf_main, ovf_hi, set;
    logic [NT-1:0][BYTE_W-1:0]   lo_w, hi_w;
    tcfg_t                       cfg [NT];
    logic                        split0, wr_rf;

    assign wr_rf  = wr_en && (wr_sel == SEL_RUNFLAG);
    assign split0 = (cfg[0].mode == MODE_SPLIT);

    // configuration byte and run bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            run_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CFG) ctrl_q <= wr_data[7:0];
            if (wr_rf)             run_q  <= wr_data[1:0];
        end
    end

    tt_pin_sampler #(.N(NT)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(fall)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        logic en;
        assign cfg[i] = tcfg_t'(ctrl_q[4*i +: 4]);
        assign en     = run_q[i] & (~cfg[i].gate_en | gate_pin[i]);
        assign inc[i] = en & (cfg[i].use_pin ? fall[i] : tick);

        tt_unit #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(i == 0)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (cfg[i].mode),
            .step     (inc[i]),
            .hi_step  ((i == 0) ? (tick & run_q[1]) : 1'b0),
            .wr_lo    (wr_en && (wr_sel == 3'(2*i))),
            .wr_hi    (wr_en && (wr_sel == 3'(2*i+1))),
            .wr_data  (wr_data),
            .lo       (lo_w[i]),
            .hi       (hi_w[i]),
            .ovf_main (ovf_main[i]),
            .ovf_hi   (ovf_hi[i])
        );
    end

    assign set[0] = ovf_main[0];
    assign set[1] = split0 ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

    tt_flags #(.N(NT)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set), .ack(flag_ack),
        .wr(wr_rf), .wr_val(wr_data[3:2]), .flag(ovf_flag)
    );

    assign cnt0 = {hi_w[0], lo_w[0]};
    assign cnt1 = {hi_w[1], lo_w[1]};
endmodule

// File: rtl/twin_timer_chk.sv
// Property checker for twin_timer, bound to every instance.
module twin_timer_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_sel,
    input logic [BYTE_W-1:0]   wr_data,
    input logic [1:0]          flag_ack,
    input logic [2*BYTE_W-1:0] cnt0,
    input logic [2*BYTE_W-1:0] cnt1,
    input logic [1:0]          ovf_flag,
    input logic [7:0]          ctrl_q,
    input logic [1:0]          run_q
);
    // R9: a flag only drops after an acknowledge or a run/flag write
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ovf_flag[0])) |-> $past(flag_ack[0] || (wr_en && wr_sel == 3'd5)));

    // R7: timer 1 in mode 3 keeps its count unless written
    assert_t1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_q[5:4] == 2'd3) && !$past(wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3)))
        |-> (cnt1 == $past(cnt1)));

    // R2: stopped timer 0 (not split) does not move
    assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!run_q[0] && ctrl_q[1:0] != 2'd3 && !(wr_en && wr_sel <= 3'd1)))
        |-> (cnt0 == $past(cnt0)));

    // R10: a low-byte write always lands, whatever the step
    assert_wr_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_sel == 3'd0)) |-> (cnt0[BYTE_W-1:0] == $past(wr_data)));

    // R6: in reload mode the high byte only changes by write
    assert_reload_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_q[1:0] == 2'd2 && !(wr_en && wr_sel == 3'd1)))
        |-> (cnt0[2*BYTE_W-1:BYTE_W] == $past(cnt0[2*BYTE_W-1:BYTE_W])));

    // R4: in prescaled mode low-byte bits above the prescaler hold
    assert_pre_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_q[1:0] == 2'd0 && !(wr_en && wr_sel == 3'd0)))
        |-> (cnt0[7:5] == $past(cnt0[7:5])));
endmodule

bind twin_timer twin_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_ack(flag_ack), .cnt0(cnt0), .cnt1(cnt1), .ovf_flag(ovf_flag),
    .ctrl_q(ctrl_q), .run_q(run_q)
);

// File: tb/twin_timer_bench.sv
module twin_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  cnt_pin = '0, gate_pin = '0, flag_ack = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cnt0, cnt1;
    logic [1:0]  ovf_flag;

    int checks = 0, failures = 0, cycles = 0, tick_per = 1, tdiv = 0;
    bit started = 0;
    string cur_req = "R1";

    int m_lo[2], m_hi[2];
    int m_ctrl = 0, m_run = 0, m_flag = 0;
    bit m_samp[2];

    twin_timer u_twin_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_ack(flag_ack),
        .cnt0(cnt0), .cnt1(cnt1), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    // one step of a non-split timer; returns 1 on overflow
    function automatic bit bump(input int md, inout int lo, inout int hi);
        int v;
        bump = 0;
        if (md == 0) begin
            if ((lo & 31) == 31) begin
                lo = lo & ~31;
                if (hi == 255) begin hi = 0; bump = 1; end else hi = hi + 1;
            end else lo = lo + 1;
        end else if (md == 1) begin
            v = hi * 256 + lo + 1;
            if (v == 65536) begin v = 0; bump = 1; end
            hi = v / 256; lo = v % 256;
        end else begin
            if (lo == 255) begin lo = hi; bump = 1; end else lo = lo + 1;
        end
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin : ref_model
        int md[2];
        bit inc[2], fl[2], wl[2], wh[2];
        bit split, s0, s1, ov;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_samp[i] = 0; end
            m_ctrl = 0; m_run = 0; m_flag = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                fl[i]  = tick && m_samp[i] && !cnt_pin[i];
                md[i]  = (m_ctrl >> (4*i)) & 3;
                inc[i] = ((m_run >> i) & 1) && (((m_ctrl >> (4*i+3)) & 1) == 0 || gate_pin[i])
                         && ((((m_ctrl >> (4*i+2)) & 1) != 0) ? fl[i] : tick);
                wl[i]  = wr_en && (int'(wr_sel) == 2*i);
                wh[i]  = wr_en && (int'(wr_sel) == 2*i+1);
            end
            for (int i = 0; i < 2; i++) if (tick) m_samp[i] = cnt_pin[i];
            split = (md[0] == 3); s0 = 0; s1 = 0;
            if (split) begin
                if (inc[0] && !wl[0]) begin
                    if (m_lo[0] == 255) begin m_lo[0] = 0; s0 = 1; end else m_lo[0]++;
                end
                if (tick && ((m_run >> 1) & 1) && !wh[0]) begin
                    if (m_hi[0] == 255) begin m_hi[0] = 0; s1 = 1; end else m_hi[0]++;
                end
            end else if (inc[0] && !wl[0] && !wh[0]) s0 = bump(md[0], m_lo[0], m_hi[0]);
            if (md[1] != 3 && inc[1] && !wl[1] && !wh[1]) begin
                ov = bump(md[1], m_lo[1], m_hi[1]);
                if (!split) s1 = ov;
            end
            for (int i = 0; i < 2; i++) begin
                if (wl[i]) m_lo[i] = wr_data;
                if (wh[i]) m_hi[i] = wr_data;
            end
            if (wr_en && wr_sel == 3'd4) m_ctrl = wr_data;
            if (wr_en && wr_sel == 3'd5) begin
                m_run  = wr_data & 3;
                m_flag = (wr_data >> 2) & 3;
            end else begin
                if (s0) m_flag |= 1; else if (flag_ack[0]) m_flag &= ~1;
                if (s1) m_flag |= 2; else if (flag_ack[1]) m_flag &= ~2;
            end
        end
    end

    // compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (cnt0 != 16'(m_hi[0] * 256 + m_lo[0])) begin
                failures++;
                $display("FAIL %s cnt0 actual=%h expected=%h", cur_req, cnt0, m_hi[0] * 256 + m_lo[0]);
            end
            checks++;
            if (cnt1 != 16'(m_hi[1] * 256 + m_lo[1])) begin
                failures++;
                $display("FAIL %s cnt1 actual=%h expected=%h", cur_req, cnt1, m_hi[1] * 256 + m_lo[1]);
            end
            checks++;
            if (ovf_flag != 2'(m_flag)) begin
                failures++;
                $display("FAIL %s ovf_flag actual=%b expected=%b", cur_req, ovf_flag, 2'(m_flag));
            end
        end
    end

    // tick generator with a programmable period
    always @(negedge clk) begin
        tdiv++;
        tick = (tick_per <= 1) ? 1'b1 : ((tdiv % tick_per) == 0);
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        cur_req = "R1";  idle(4); rst_n = 1'b1; idle(3);
        // R5 16-bit wrap
        cur_req = "R5";  wreg(4, 8'h11); wreg(0, 8'hF0); wreg(1, 8'hFF); wreg(5, 1); idle(24);
        // R9 acknowledge and write-clear
        cur_req = "R9";  @(negedge clk); flag_ack = 2'b01; @(negedge clk); flag_ack = 2'b00;
        wreg(5, 8'h0D); idle(2); wreg(5, 8'h01); idle(2);
        // R10 write while counting
        cur_req = "R10"; wreg(0, 8'h10); wreg(1, 8'h22); idle(3);
        // R4 prescaled mode, upper low-byte bits preset
        cur_req = "R4";  wreg(5, 0); wreg(4, 8'h10); wreg(0, 8'hFC); wreg(1, 8'hFF); wreg(5, 1); idle(80);
        // R6 reload mode on timer 1
        cur_req = "R6";  wreg(4, 8'h20); wreg(2, 8'hFD); wreg(3, 8'hF0); wreg(5, 2); idle(40);
        // R2 gating with a slower tick
        cur_req = "R2";  tick_per = 3; wreg(4, 8'h09); wreg(0, 8'h00); wreg(5, 1);
        gate_pin = 2'b00; idle(12); gate_pin = 2'b01; idle(12); gate_pin = 2'b00; idle(6);
        // R3 edge counting, slow and fast pin activity
        cur_req = "R3";  tick_per = 1; wreg(4, 8'h05);
        for (int k = 0; k < 10; k++) begin cnt_pin[0] = 1'b1; idle(2); cnt_pin[0] = 1'b0; idle(2); end
        tick_per = 4;
        for (int k = 0; k < 12; k++) begin cnt_pin[0] = ~cnt_pin[0]; idle(1); end
        tick_per = 1; cnt_pin = '0;
        // R8 split mode with timer 1 still counting
        cur_req = "R8";  wreg(4, 8'h13); wreg(1, 8'hFE); wreg(0, 8'hFA); wreg(3, 8'hFF); wreg(2, 8'hF8);
        wreg(5, 3); idle(40);
        // R7 timer 1 held
        cur_req = "R7";  wreg(4, 8'h31); idle(20);
        // random mix of everything
        cur_req = "R10";
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            cnt_pin  = 2'($urandom);
            gate_pin = 2'($urandom);
            flag_ack = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            wr_en    = (($urandom % 6) == 0);
            wr_sel   = 3'($urandom % 6);
            wr_data  = 8'($urandom);
            if (wr_sel == 3'd0 || wr_sel == 3'd2) wr_data = 8'hF0 | wr_data;
            tick_per = 1 + int'($urandom % 2);
        end
        @(negedge clk); wr_en = 1'b0; flag_ack = '0;
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule